// File: doc/BRIEF.md
# Branch-aware program counter unit

This block holds the fetch address of a simple in-order core and chooses its next value every cycle. When the instruction in flight is not a taken branch, the address steps forward by one 32-bit instruction word. When it is a taken branch, the block overwrites the address with a target it builds from the instruction itself. The instruction carries a signed word offset, which the block scales to bytes and sign-extends. It then adds a fixed bias of two instruction words, because the fetch address has already moved two words past the branch when the branch is applied.

The block does not evaluate condition flags. An external unit evaluates them and passes the result in as a single pass bit. One condition code means "always", and the block treats it as unconditional without looking at the pass bit. A taken branch with the link bit set also raises a one-cycle request to write the return address into the register file. Instruction memory, flushing and the register write itself belong to neighbouring blocks.

Top module: `branch_pc_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0x00000000, and branch_taken_o and link_we_o are 0.
- R2: On a clock edge with insn_valid_i high and no taken branch, pc_o becomes its previous value plus 4.
- R3: On a clock edge with insn_valid_i low, pc_o keeps its value, and branch_taken_o and link_we_o are 0 in the following cycle.
- R4: An instruction is in the branch class only when insn_i[27:25] is 3'b101. Words with any other value there, for example 3'b100 or 3'b111, step the PC by 4 and never raise branch_taken_o.
- R5: A taken branch at address A loads A + 8 + (sign-extended insn_i[23:0] << 2). For example, 0xEA000001 at A gives A + 12.
- R6: If insn_i[23] is set, the offset is negative. For example, 0xEAFFFFFE at A gives A, a branch to itself.
- R7: The condition field is insn_i[31:28]. The value 4'b1110 means always taken, whatever cond_pass_i is. For any other value, the branch is taken only if cond_pass_i is high; if it is not taken, the PC steps by 4.
- R8: branch_taken_o is high for exactly the one cycle in which pc_o first shows the branch target.
- R9: If insn_i[24] (the link bit) is set and the branch is taken, link_we_o is high for one cycle, in the same cycle as branch_taken_o, and link_addr_o is A + 4. A branch that is not taken never raises link_we_o.
- R10: All PC arithmetic wraps modulo 2^32, and pc_o[1:0] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word at the current PC |
| insn_valid_i | input | 1 | insn_i is valid this cycle |
| cond_pass_i | input | 1 | The external flag unit reports that the condition holds |
| pc_o | output | 32 | Current program counter |
| branch_taken_o | output | 1 | Pulse: pc_o now holds a branch target |
| link_we_o | output | 1 | Pulse: request to write the return address |
| link_addr_o | output | 32 | Return address of the linking branch |

## Verification
The bench builds the block with the default parameters: a 32-bit address, a 24-bit word offset, a shift of two bits and a bias of two words. These values make the self-branch case reachable and give an offset range that can push the target below address zero. The bench uses that range to steer the PC to 0xFFFFFFF8 with a backward branch, then steps it through the wrap to zero. The bench also runs conditional branches with the pass bit low and high, and linking branches both taken and not taken.

// File: rtl/branch_pc_pkg.sv
package branch_pc_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned OFF_W     = 24;
  localparam int unsigned COND_W    = 4;
  localparam int unsigned CLASS_W   = 3;
  localparam int unsigned WORD_SH   = 2;
  localparam int unsigned BIAS_WRDS = 2;

  localparam logic [COND_W-1:0]  COND_ALWAYS  = 4'b1110;
  localparam logic [CLASS_W-1:0] CLASS_BRANCH = 3'b101;

  typedef struct packed {
    logic [COND_W-1:0]  cond;
    logic [CLASS_W-1:0] cls;
    logic               link;
    logic [OFF_W-1:0]   off;
  } br_fields_t;

  typedef struct packed {
    logic             is_branch;
    logic             always_cond;
    logic             link;
    logic [OFF_W-1:0] off;
  } br_dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import branch_pc_pkg::*;
(
  input  logic [XLEN-1:0] insn_i,
  output br_dec_t         dec_o
);
  br_fields_t f;
  assign f = br_fields_t'(insn_i);

  always_comb begin
    dec_o.is_branch   = (f.cls == CLASS_BRANCH);
    dec_o.always_cond = (f.cond == COND_ALWAYS);
    dec_o.link        = f.link;
    dec_o.off         = f.off;
  end
endmodule

// File: rtl/br_cond_gate.sv
module br_cond_gate
  import branch_pc_pkg::*;
(
  input  logic    valid_i,
  input  logic    pass_i,
  input  br_dec_t dec_i,
  output logic    take_o,
  output logic    link_o
);
  logic cond_ok;
  assign cond_ok = dec_i.always_cond | pass_i;
  assign take_o  = valid_i & dec_i.is_branch & cond_ok;
  assign link_o  = take_o & dec_i.link;
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OW    = 24,
  parameter int unsigned SH    = 2,
  parameter int unsigned BIASW = 2
) (
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] target_o,
  output logic [AW-1:0] seq_o
);
  localparam int unsigned EXT_W = AW - OW - SH;
  localparam logic [AW-1:0] STEP = AW'(1) << SH;
  localparam logic [AW-1:0] BIAS = AW'(BIASW) << SH;

  logic [AW-1:0] off_bytes;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_bytes = {{EXT_W{off_i[OW-1]}}, off_i, {SH{1'b0}}};
    end else begin : g_trunc
      logic [OW+SH-1:0] wide;
      assign wide      = {off_i, {SH{1'b0}}};
      assign off_bytes = wide[AW-1:0];
    end
  endgenerate

  // modulo 2^AW by width
  assign target_o = pc_i + BIAS + off_bytes;
  assign seq_o    = pc_i + STEP;
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import branch_pc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] insn_i,
  input  logic        insn_valid_i,
  input  logic        cond_pass_i,
  output logic [31:0] pc_o,
  output logic        branch_taken_o,
  output logic        link_we_o,
  output logic [31:0] link_addr_o
);
  br_dec_t         dec;
  logic            take, link;
  logic [XLEN-1:0] pc_q, target, seq;
  logic            taken_q, link_q;
  logic [XLEN-1:0] link_addr_q;

  br_decode i_dec (
    .insn_i (insn_i),
    .dec_o  (dec)
  );

  br_cond_gate i_gate (
    .valid_i (insn_valid_i),
    .pass_i  (cond_pass_i),
    .dec_i   (dec),
    .take_o  (take),
    .link_o  (link)
  );

  br_target #(
    .AW    (XLEN),
    .OW    (OFF_W),
    .SH    (WORD_SH),
    .BIASW (BIAS_WRDS)
  ) i_tgt (
    .pc_i     (pc_q),
    .off_i    (dec.off),
    .target_o (target),
    .seq_o    (seq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= RESET_PC;
      taken_q     <= 1'b0;
      link_q      <= 1'b0;
      link_addr_q <= '0;
    end else begin
      taken_q <= take;
      link_q  <= link;
      if (insn_valid_i) pc_q <= take ? target : seq;
      if (link) link_addr_q <= seq;
    end
  end

  assign pc_o           = pc_q;
  assign branch_taken_o = taken_q;
  assign link_we_o      = link_q;
  assign link_addr_o    = link_addr_q;
endmodule

// File: rtl/branch_pc_unit_chk.sv
module branch_pc_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] insn_i,
  input logic        insn_valid_i,
  input logic        cond_pass_i,
  input logic [31:0] pc_o,
  input logic        branch_taken_o,
  input logic        link_we_o,
  input logic [31:0] link_addr_o
);
  // R1
  always_comb if (!rst_ni) reset_state_chk: assert (pc_o == 32'h0 && !branch_taken_o && !link_we_o);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i && insn_i[27:25] != 3'b101 |=> pc_o == $past(pc_o) + 32'd4);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !insn_valid_i |=> $stable(pc_o) && !branch_taken_o && !link_we_o);

  // R4
  non_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_i[27:25] != 3'b101 |=> !branch_taken_o);

  // R7
  always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i && insn_i[27:25] == 3'b101 && insn_i[31:28] == 4'b1110 |=> branch_taken_o);

  // R7
  cond_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_i && insn_i[31:28] != 4'b1110 && !cond_pass_i |=> !branch_taken_o);

  // R9
  link_with_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> branch_taken_o);

  // R9
  link_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) == 1'b0 && link_we_o |-> link_addr_o == $past(pc_o) + 32'd4);

  // R10
  pc_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);
endmodule

bind branch_pc_unit branch_pc_unit_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .insn_i         (insn_i),
  .insn_valid_i   (insn_valid_i),
  .cond_pass_i    (cond_pass_i),
  .pc_o           (pc_o),
  .branch_taken_o (branch_taken_o),
  .link_we_o      (link_we_o),
  .link_addr_o    (link_addr_o)
);

// File: tb/test_branch_pc_unit.sv
module test_branch_pc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn_i = 32'h0;
  logic        insn_valid_i = 1'b0;
  logic        cond_pass_i = 1'b0;
  logic [31:0] pc_o, link_addr_o;
  logic        branch_taken_o, link_we_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] NOP = 32'hE3A0_1001;

  always #5 clk_i = ~clk_i;

  branch_pc_unit i_branch_pc_unit (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .insn_i         (insn_i),
    .insn_valid_i   (insn_valid_i),
    .cond_pass_i    (cond_pass_i),
    .pc_o           (pc_o),
    .branch_taken_o (branch_taken_o),
    .link_we_o      (link_we_o),
    .link_addr_o    (link_addr_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic step(input logic [31:0] insn, input logic vld, input logic pass);
    insn_i = insn;
    insn_valid_i = vld;
    cond_pass_i = pass;
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] br_tgt(input logic [31:0] a, input logic [23:0] f);
    return a + 32'd8 + ({{6{f[23]}}, f, 2'b00});
  endfunction

  task automatic t_reset();
    chk("R1", "pc", pc_o, 32'h0);
    chk("R1", "taken", {31'b0, branch_taken_o}, 32'h0);
    chk("R1", "link", {31'b0, link_we_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_seq();
    logic [31:0] a;
    for (int i = 0; i < 3; i++) begin
      a = pc_o;
      step(NOP, 1'b1, 1'b0);
      chk("R2", "pc step", pc_o, a + 32'd4);
      chk("R2", "taken", {31'b0, branch_taken_o}, 32'h0);
    end
  endtask

  task automatic t_idle();
    logic [31:0] a;
    a = pc_o;
    step(32'hEB00_0001, 1'b0, 1'b1);
    chk("R3", "pc hold", pc_o, a);
    chk("R3", "taken", {31'b0, branch_taken_o}, 32'h0);
    chk("R3", "link", {31'b0, link_we_o}, 32'h0);
  endtask

  task automatic t_fwd();
    logic [31:0] a;
    a = pc_o;
    step(32'hEA00_0001, 1'b1, 1'b0);
    chk("R5", "fwd target", pc_o, a + 32'd12);
    chk("R8", "taken pulse", {31'b0, branch_taken_o}, 32'h1);
    chk("R9", "no link", {31'b0, link_we_o}, 32'h0);
    step(NOP, 1'b1, 1'b0);
    chk("R8", "taken drops", {31'b0, branch_taken_o}, 32'h0);
    chk("R2", "after branch", pc_o, a + 32'd16);
  endtask

  task automatic t_back();
    logic [31:0] a;
    a = pc_o;
    step(32'hEAFF_FFFE, 1'b1, 1'b0);
    chk("R6", "self branch", pc_o, a);
    chk("R8", "taken", {31'b0, branch_taken_o}, 32'h1);
    a = pc_o;
    step(32'hEAFF_FFFB, 1'b1, 1'b0);
    chk("R6", "back target", pc_o, br_tgt(a, 24'hFFFFFB));
  endtask

  task automatic t_class();
    logic [31:0] a;
    a = pc_o;
    step(32'hE800_0005, 1'b1, 1'b1);
    chk("R4", "class 100", pc_o, a + 32'd4);
    chk("R4", "class 100 taken", {31'b0, branch_taken_o}, 32'h0);
    a = pc_o;
    step(32'hEE00_0005, 1'b1, 1'b1);
    chk("R4", "class 111", pc_o, a + 32'd4);
    chk("R4", "class 111 taken", {31'b0, branch_taken_o}, 32'h0);
  endtask

  task automatic t_cond();
    logic [31:0] a;
    a = pc_o;
    step(32'h0A00_0003, 1'b1, 1'b0);
    chk("R7", "cond fail pc", pc_o, a + 32'd4);
    chk("R7", "cond fail taken", {31'b0, branch_taken_o}, 32'h0);
    a = pc_o;
    step(32'h0A00_0003, 1'b1, 1'b1);
    chk("R7", "cond pass pc", pc_o, a + 32'd20);
    chk("R7", "cond pass taken", {31'b0, branch_taken_o}, 32'h1);
    a = pc_o;
    step(32'hEA00_0000, 1'b1, 1'b0);
    chk("R7", "always pc", pc_o, a + 32'd8);
  endtask

  task automatic t_link();
    logic [31:0] a;
    a = pc_o;
    step(32'hEB00_0002, 1'b1, 1'b0);
    chk("R9", "link pc", pc_o, a + 32'd16);
    chk("R9", "link we", {31'b0, link_we_o}, 32'h1);
    chk("R9", "link addr", link_addr_o, a + 32'd4);
    chk("R9", "link with taken", {31'b0, branch_taken_o}, 32'h1);
    step(NOP, 1'b1, 1'b0);
    chk("R9", "link drops", {31'b0, link_we_o}, 32'h0);
    a = pc_o;
    step(32'h1B00_0002, 1'b1, 1'b0);
    chk("R9", "untaken link", {31'b0, link_we_o}, 32'h0);
    chk("R9", "untaken pc", pc_o, a + 32'd4);
  endtask

  task automatic t_wrap();
    logic [31:0] a;
    logic [31:0] words;
    a = pc_o;
    words = (32'd0 - (a + 32'd16)) >> 2;
    step({8'hEA, words[23:0]}, 1'b1, 1'b0);
    chk("R10", "wrap below zero", pc_o, 32'hFFFF_FFF8);
    step(NOP, 1'b1, 1'b0);
    chk("R10", "top word", pc_o, 32'hFFFF_FFFC);
    step(NOP, 1'b1, 1'b0);
    chk("R10", "wrap to zero", pc_o, 32'h0);
    chk("R10", "align", {30'b0, pc_o[1:0]}, 32'h0);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_seq();
    t_idle();
    t_fwd();
    t_back();
    t_class();
    t_cond();
    t_link();
    t_wrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule